// File: doc/BRIEF.md
# Zone-Based Access Permission Checker

This unit sits after the address translation lookup and decides whether one memory access may go ahead. It accepts at most one request per cycle. Each request carries the privilege mode, an access class, the 2-bit zone code already chosen from the zone table, and three bits from the translation entry: write-enable, execute-enable and guarded. One cycle later the unit returns exactly one verdict, one-hot encoded, together with a valid strobe.

The zone code can override the page's own permission bits, and it does so in different ways in user mode and supervisor mode. Zone 00 locks a user out of the page completely. Zone 11 grants a user full access. In supervisor mode, the upper zone codes grant full access. Some cache hints never raise a fault. If they hit a condition that would fault, they finish as no-ops instead. Requests that arrive while translation is disabled always pass.

Top module: `mmu_zone_perm_chk`

## Requirements
- R1: With translation disabled (`xlate_en_i`=0), every request gets verdict permit, whatever its other fields.
- R2: In user mode with zone 00, load (1), store (2), data block zero (3), data flush (4) and instruction invalidate (5) get a data storage fault (verdict bit 2). An instruction fetch (0) gets an instruction storage fault (bit 3).
- R3: In user mode with zone 00, data touch (6) and touch-for-store (7) get verdict no-op (bit 1).
- R4: In user mode, a store or data block zero to a page with write-enable clear gets a data storage fault unless the zone is 11. With zone 11 it is permitted.
- R5: In supervisor mode, a store, data block zero, data invalidate (8) or congruence-class invalidate (9) to a page with write-enable clear gets a data storage fault only for zones 00 and 01. Zones 10 and 11 permit it.
- R6: Data invalidate and congruence-class invalidate issued in user mode get a program fault (bit 4) and never a storage fault.
- R7: Data block allocate (10) never gets a data storage fault. When user zone 00 applies, or write-enable is clear and the zone does not override it, the verdict is no-op. Otherwise it is permit.
- R8: In user mode, an instruction fetch faults (bit 3) when the zone is 00, or when execute-enable is clear and the zone is not 11.
- R9: In supervisor mode, an instruction fetch with execute-enable clear faults only for zones 00 and 01.
- R10: An instruction fetch from a guarded page faults in both modes, whatever the zone.
- R11: The verdict appears one cycle after the request with `vld_o`=1 and exactly one bit set. The bit positions are: bit 0 permit, bit 1 no-op, bit 2 data storage fault, bit 3 instruction storage fault, bit 4 program fault. When several conditions apply, the priority is program, then storage, then no-op, then permit. A cycle with no request gives `vld_o`=0 and a verdict of zero. A synchronous reset clears both outputs.
- R12: Every other combination is permitted. This includes supervisor loads in any zone and the reserved class codes 11 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid_i | input | 1 | A request is presented this cycle |
| xlate_en_i | input | 1 | Address translation is enabled for this request |
| supervisor_i | input | 1 | 1 = supervisor mode, 0 = user mode |
| acc_class_i | input | 4 | Access class code |
| zone_i | input | 2 | Zone code selected for the page |
| pg_wr_i | input | 1 | Page write-enable bit |
| pg_ex_i | input | 1 | Page execute-enable bit |
| pg_g_i | input | 1 | Page guarded bit |
| vld_o | output | 1 | Verdict valid, one cycle after the request |
| verdict_o | output | 5 | One-hot verdict |

## Verification
The assertions assume that the request fields are stable and known whenever `req_valid_i` is high. They also assume that reset is held for at least one clock before the first request. The bench drives every field from a negative clock edge and holds it for a full cycle. It applies reset before any traffic and again for a single cycle in the middle of the run. The sweep covers every combination of mode, class (including the reserved codes), zone and page bits, so no field is ever left undriven.

// File: rtl/mmu_perm_pkg.sv
package mmu_perm_pkg;

  localparam int CLASS_W   = 4;
  localparam int ZONE_W    = 2;
  localparam int VERDICT_W = 5;

  localparam logic [CLASS_W-1:0] AC_FETCH    = 4'd0;
  localparam logic [CLASS_W-1:0] AC_LOAD     = 4'd1;
  localparam logic [CLASS_W-1:0] AC_STORE    = 4'd2;
  localparam logic [CLASS_W-1:0] AC_DCZERO   = 4'd3;
  localparam logic [CLASS_W-1:0] AC_DCFLUSH  = 4'd4;
  localparam logic [CLASS_W-1:0] AC_ICINVAL  = 4'd5;
  localparam logic [CLASS_W-1:0] AC_TOUCH    = 4'd6;
  localparam logic [CLASS_W-1:0] AC_TOUCH_ST = 4'd7;
  localparam logic [CLASS_W-1:0] AC_DCINVAL  = 4'd8;
  localparam logic [CLASS_W-1:0] AC_CCINVAL  = 4'd9;
  localparam logic [CLASS_W-1:0] AC_DCALLOC  = 4'd10;

  localparam logic [ZONE_W-1:0] ZONE_LOCKED = 2'b00;
  localparam logic [ZONE_W-1:0] ZONE_OPEN   = 2'b11;

  localparam int VB_PERMIT = 0;
  localparam int VB_NOOP   = 1;
  localparam int VB_DSF    = 2;
  localparam int VB_ISF    = 3;
  localparam int VB_PROG   = 4;

  // zone grants full access regardless of page bits
  function automatic logic zone_overrides(input logic sup, input logic [ZONE_W-1:0] z);
    return sup ? z[ZONE_W-1] : (z == ZONE_OPEN);
  endfunction

  function automatic logic is_privileged(input logic [CLASS_W-1:0] c);
    return (c == AC_DCINVAL) || (c == AC_CCINVAL);
  endfunction

  function automatic logic is_write_class(input logic [CLASS_W-1:0] c, input logic sup);
    return (c == AC_STORE) || (c == AC_DCZERO) || (sup && is_privileged(c));
  endfunction

  function automatic logic is_lock_denied(input logic [CLASS_W-1:0] c);
    return (c == AC_LOAD) || (c == AC_STORE) || (c == AC_DCZERO) ||
           (c == AC_DCFLUSH) || (c == AC_ICINVAL);
  endfunction

  function automatic logic is_touch(input logic [CLASS_W-1:0] c);
    return (c == AC_TOUCH) || (c == AC_TOUCH_ST);
  endfunction

  function automatic logic [VERDICT_W-1:0] pick_verdict(
      input logic xl, input logic prog, input logic dsf,
      input logic isf, input logic noop);
    logic [VERDICT_W-1:0] v;
    v = '0;
    if (!xl)       v[VB_PERMIT] = 1'b1;
    else if (prog) v[VB_PROG]   = 1'b1;
    else if (dsf)  v[VB_DSF]    = 1'b1;
    else if (isf)  v[VB_ISF]    = 1'b1;
    else if (noop) v[VB_NOOP]   = 1'b1;
    else           v[VB_PERMIT] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/perm_data_eval.sv
module perm_data_eval
  import mmu_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               supervisor_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [ZONE_W-1:0]  zone_i,
  input  logic               pg_wr_i,
  output logic               dsf_hit_o,
  output logic               noop_hit_o,
  output logic               prog_hit_o
);

  logic user_lock;
  logic wr_blocked;
  logic write_fault;
  logic alloc_would_fault;

  assign user_lock         = !supervisor_i && (zone_i == ZONE_LOCKED);
  assign wr_blocked        = !pg_wr_i && !zone_overrides(supervisor_i, zone_i);
  assign write_fault       = is_write_class(class_i, supervisor_i) && wr_blocked;
  assign alloc_would_fault = user_lock || wr_blocked;

  assign prog_hit_o = !supervisor_i && is_privileged(class_i);
  assign dsf_hit_o  = (user_lock && is_lock_denied(class_i)) || write_fault;
  assign noop_hit_o = (user_lock && is_touch(class_i)) ||
                      ((class_i == AC_DCALLOC) && alloc_would_fault);

  AST_ALLOC_NO_DSF: assert property (@(posedge clk) disable iff (rst)
    (class_i == AC_DCALLOC) |-> !dsf_hit_o); // R7
  AST_TOUCH_NO_DSF: assert property (@(posedge clk) disable iff (rst)
    is_touch(class_i) |-> !dsf_hit_o); // R3
  AST_SUP_NO_PROG: assert property (@(posedge clk) disable iff (rst)
    supervisor_i |-> !prog_hit_o); // R6

endmodule

// File: rtl/perm_fetch_eval.sv
module perm_fetch_eval
  import mmu_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               supervisor_i,
  input  logic [CLASS_W-1:0] class_i,
  input  logic [ZONE_W-1:0]  zone_i,
  input  logic               pg_ex_i,
  input  logic               pg_g_i,
  output logic               isf_hit_o
);

  logic is_fetch;
  logic user_lock;
  logic ex_blocked;

  assign is_fetch   = (class_i == AC_FETCH);
  assign user_lock  = !supervisor_i && (zone_i == ZONE_LOCKED);
  assign ex_blocked = !pg_ex_i && !zone_overrides(supervisor_i, zone_i);
  assign isf_hit_o  = is_fetch && (pg_g_i || user_lock || ex_blocked);

  AST_GUARD_FETCH: assert property (@(posedge clk) disable iff (rst)
    (is_fetch && pg_g_i) |-> isf_hit_o); // R10
  AST_ISF_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    !is_fetch |-> !isf_hit_o); // R12

endmodule

// File: rtl/perm_verdict_reg.sv
module perm_verdict_reg
  import mmu_perm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic                 xlate_en_i,
  input  logic                 prog_hit_i,
  input  logic                 dsf_hit_i,
  input  logic                 isf_hit_i,
  input  logic                 noop_hit_i,
  output logic                 vld_o,
  output logic [VERDICT_W-1:0] verdict_o
);

  logic [VERDICT_W-1:0] verdict_d;

  assign verdict_d = req_valid_i ?
      pick_verdict(xlate_en_i, prog_hit_i, dsf_hit_i, isf_hit_i, noop_hit_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o     <= 1'b0;
      verdict_o <= '0;
    end else begin
      vld_o     <= req_valid_i;
      verdict_o <= verdict_d;
    end
  end

  AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ($countones(verdict_o) == 1)); // R11
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> (verdict_o == '0)); // R11
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid_i |=> vld_o); // R11
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !vld_o); // R11

endmodule

// File: rtl/mmu_zone_perm_chk.sv
module mmu_zone_perm_chk
  import mmu_perm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid_i,
  input  logic                 xlate_en_i,
  input  logic                 supervisor_i,
  input  logic [CLASS_W-1:0]   acc_class_i,
  input  logic [ZONE_W-1:0]    zone_i,
  input  logic                 pg_wr_i,
  input  logic                 pg_ex_i,
  input  logic                 pg_g_i,
  output logic                 vld_o,
  output logic [VERDICT_W-1:0] verdict_o
);

  logic dsf_hit;
  logic noop_hit;
  logic prog_hit;
  logic isf_hit;

  perm_data_eval u_data (
    .clk          (clk),
    .rst          (rst),
    .supervisor_i (supervisor_i),
    .class_i      (acc_class_i),
    .zone_i       (zone_i),
    .pg_wr_i      (pg_wr_i),
    .dsf_hit_o    (dsf_hit),
    .noop_hit_o   (noop_hit),
    .prog_hit_o   (prog_hit)
  );

  perm_fetch_eval u_fetch (
    .clk          (clk),
    .rst          (rst),
    .supervisor_i (supervisor_i),
    .class_i      (acc_class_i),
    .zone_i       (zone_i),
    .pg_ex_i      (pg_ex_i),
    .pg_g_i       (pg_g_i),
    .isf_hit_o    (isf_hit)
  );

  perm_verdict_reg u_vreg (
    .clk         (clk),
    .rst         (rst),
    .req_valid_i (req_valid_i),
    .xlate_en_i  (xlate_en_i),
    .prog_hit_i  (prog_hit),
    .dsf_hit_i   (dsf_hit),
    .isf_hit_i   (isf_hit),
    .noop_hit_i  (noop_hit),
    .vld_o       (vld_o),
    .verdict_o   (verdict_o)
  );

  AST_XLATE_OFF_PERMIT: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && !xlate_en_i) |=> verdict_o[VB_PERMIT]); // R1
  AST_USER_PRIV_PROG: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && xlate_en_i && !supervisor_i && is_privileged(acc_class_i))
      |=> verdict_o[VB_PROG]); // R6
  AST_GUARD_ISF: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && xlate_en_i && (acc_class_i == AC_FETCH) && pg_g_i)
      |=> verdict_o[VB_ISF]); // R10
  AST_SUP_HI_ZONE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && xlate_en_i && supervisor_i && zone_i[ZONE_W-1] &&
     is_write_class(acc_class_i, 1'b1)) |=> verdict_o[VB_PERMIT]); // R5

endmodule

// File: tb/mmu_zone_perm_chk_tb.sv
module mmu_zone_perm_chk_tb;

  localparam logic [4:0] V_P = 5'b00001;
  localparam logic [4:0] V_N = 5'b00010;
  localparam logic [4:0] V_D = 5'b00100;
  localparam logic [4:0] V_I = 5'b01000;
  localparam logic [4:0] V_G = 5'b10000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid_i = 1'b0;
  logic       xlate_en_i = 1'b0;
  logic       supervisor_i = 1'b0;
  logic [3:0] acc_class_i = '0;
  logic [1:0] zone_i = '0;
  logic       pg_wr_i = 1'b0;
  logic       pg_ex_i = 1'b0;
  logic       pg_g_i = 1'b0;
  logic       vld_o;
  logic [4:0] verdict_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic       vld;
    logic [4:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  mmu_zone_perm_chk u_dut (
    .clk(clk), .rst(rst), .req_valid_i(req_valid_i), .xlate_en_i(xlate_en_i),
    .supervisor_i(supervisor_i), .acc_class_i(acc_class_i), .zone_i(zone_i),
    .pg_wr_i(pg_wr_i), .pg_ex_i(pg_ex_i), .pg_g_i(pg_g_i),
    .vld_o(vld_o), .verdict_o(verdict_o)
  );

  // independent reference, organised per access class
  function automatic logic [4:0] model(input logic xl, input logic sup,
      input logic [3:0] c, input logic [1:0] z, input logic wr,
      input logic ex, input logic g);
    logic user;
    logic lock;
    logic wr_deny;
    user    = !sup;
    lock    = user && (z == 2'b00);
    wr_deny = !wr && (user ? (z != 2'b11) : (z < 2'd2));
    if (!xl) return V_P;
    case (c)
      4'd0: begin
        if (g) return V_I;
        if (user) return (lock || (!ex && z != 2'b11)) ? V_I : V_P;
        return (!ex && z < 2'd2) ? V_I : V_P;
      end
      4'd1, 4'd4, 4'd5: return lock ? V_D : V_P;
      4'd2, 4'd3:       return (lock || wr_deny) ? V_D : V_P;
      4'd6, 4'd7:       return lock ? V_N : V_P;
      4'd8, 4'd9: begin
        if (user) return V_G;
        return wr_deny ? V_D : V_P;
      end
      4'd10:            return (lock || wr_deny) ? V_N : V_P;
      default:          return V_P;
    endcase
  endfunction

  task automatic drive(input logic xl, input logic sup, input logic [3:0] c,
      input logic [1:0] z, input logic wr, input logic ex, input logic g,
      input string tag);
    exp_t e;
    @(negedge clk);
    req_valid_i = 1'b1; xlate_en_i = xl; supervisor_i = sup; acc_class_i = c;
    zone_i = z; pg_wr_i = wr; pg_ex_i = ex; pg_g_i = g;
    e.vld = 1'b1; e.v = model(xl, sup, c, z, wr, ex, g); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    exp_t e;
    @(negedge clk);
    req_valid_i = 1'b0;
    e.vld = 1'b0; e.v = '0; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: output reflects inputs driven at the preceding negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (vld_o !== e.vld || verdict_o !== e.v) begin
          errors++;
          $display("FAIL %s: actual vld=%0b verdict=%b expected vld=%0b verdict=%b",
                   e.tag, vld_o, verdict_o, e.vld, e.v);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (vld_o !== 1'b0 || verdict_o !== 5'b0) begin
      errors++;
      $display("FAIL R11 reset: actual vld=%0b verdict=%b expected vld=0 verdict=00000",
               vld_o, verdict_o);
    end
    @(negedge clk);
    rst = 1'b0;

    drive(0, 0, 4'd2, 2'b00, 0, 0, 1, "R1 xlate off user store");
    drive(0, 0, 4'd8, 2'b00, 0, 0, 0, "R1 xlate off user dcinval");
    drive(1, 0, 4'd1, 2'b00, 1, 1, 0, "R2 user zone00 load");
    drive(1, 0, 4'd5, 2'b00, 1, 1, 0, "R2 user zone00 icinval");
    drive(1, 0, 4'd0, 2'b00, 1, 1, 0, "R2 user zone00 fetch");
    drive(1, 0, 4'd6, 2'b00, 1, 1, 0, "R3 user zone00 touch");
    drive(1, 0, 4'd7, 2'b00, 0, 1, 0, "R3 user zone00 touch-store");
    drive(1, 0, 4'd2, 2'b10, 0, 1, 0, "R4 user store wr0 zone10");
    drive(1, 0, 4'd3, 2'b11, 0, 1, 0, "R4 user dczero wr0 zone11");
    drive(1, 1, 4'd8, 2'b01, 0, 1, 0, "R5 sup dcinval wr0 zone01");
    drive(1, 1, 4'd9, 2'b10, 0, 1, 0, "R5 sup ccinval wr0 zone10");
    drive(1, 0, 4'd9, 2'b00, 0, 1, 0, "R6 user ccinval zone00");
    drive(1, 0, 4'd10, 2'b00, 1, 1, 0, "R7 user zone00 alloc");
    drive(1, 1, 4'd10, 2'b01, 0, 1, 0, "R7 sup alloc wr0 zone01");
    drive(1, 0, 4'd0, 2'b10, 1, 0, 0, "R8 user fetch ex0 zone10");
    drive(1, 0, 4'd0, 2'b11, 1, 0, 0, "R8 user fetch ex0 zone11");
    drive(1, 1, 4'd0, 2'b00, 1, 0, 0, "R9 sup fetch ex0 zone00");
    drive(1, 1, 4'd0, 2'b10, 1, 0, 0, "R9 sup fetch ex0 zone10");
    drive(1, 1, 4'd0, 2'b11, 1, 1, 1, "R10 sup guarded fetch");
    idle("R11 idle gap");
    drive(1, 1, 4'd1, 2'b00, 0, 0, 0, "R12 sup load zone00");
    drive(1, 0, 4'd13, 2'b00, 0, 0, 1, "R12 reserved class");

    // one-cycle reset in the middle of traffic
    @(negedge clk);
    rst = 1'b1;
    req_valid_i = 1'b1; xlate_en_i = 1'b1; acc_class_i = 4'd2;
    begin
      exp_t e;
      e.vld = 1'b0; e.v = '0; e.tag = "R11 mid-run reset";
      q.push_back(e);
    end
    @(negedge clk);
    rst = 1'b0;
    req_valid_i = 1'b0;
    begin
      exp_t e;
      e.vld = 1'b0; e.v = '0; e.tag = "R11 after reset";
      q.push_back(e);
    end

    for (int xl = 0; xl < 2; xl++)
      for (int sup = 0; sup < 2; sup++)
        for (int c = 0; c < 16; c++)
          for (int z = 0; z < 4; z++)
            for (int b = 0; b < 8; b++)
              drive(xl[0], sup[0], c[3:0], z[1:0], b[0], b[1], b[2], "sweep");
    idle("R11 final idle");
    idle("R11 final idle");
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule